// File: doc/BRIEF.md
# TDM output frame serializer

This block turns parallel audio words into time-division-multiplexed serial streams on a small set of data lanes. It does not make its own bit clock. It watches an externally supplied bit clock and frame-sync level, which are sampled in the system clock domain. On each falling edge of the bit clock it drives one new bit per lane. A frame is a run of equal slots, and every slot carries one word per lane, most significant bit first. The slot width, the slot count, the word width inside a slot and the distance in bit clocks between the frame-sync edge and the first data bit (the skew) all come from plain configuration inputs.

Each internal lane has its own per-slot mask. A masked-in slot takes a fresh word from the upstream source and pulses a per-lane take strobe, so the source can present the next word. A masked-out slot sends a fixed mute word and leaves the source alone. A swap map then routes the internal lanes onto the output pins. The frame-sync polarity can be inverted. Two independent clears exist, one for the output timing side and one for the input word side. The intended startup is: hold both clears, drop the output clear, drop the input clear, then raise enable.

Top module: `tdm_frame_serializer`

## Requirements
- R1: After the asynchronous reset, every serial pin and every take strobe is 0.
- R2: A slot lasts `slot_bits_m1_i`+1 bit clocks. The word is sent MSB first, and its width is `word_msb_i`+1 bits. Slot positions past the word width carry 0. Pins change only on the system clock edge that first sees the bit clock low after it was high.
- R3: A frame holds `slot_cnt_m1_i`+1 slots. After the last bit of the last slot, the counters wrap to bit 0 of slot 0 and keep running without a further frame-sync edge.
- R4: The active frame-sync edge is the first falling bit clock at which the sensed frame-sync is 1 after having been 0. The MSB of slot 0 appears `skew_i` falling bit clocks after that edge; with 0 it appears at the edge itself. The previous frame keeps running until the restart.
- R5: With `ws_invert_i`=1, the frame-sync input is inverted before sensing, so a high-to-low change on `fsync_i` starts a frame.
- R6: Bit s of `lane_mask_i[l*32 +: 32]` enables slot s on internal lane l. A cleared bit sends `mute_word_i` with the same MSB-first and padding rule, and does not pulse `take_o[l]`.
- R7: At the first bit of an enabled slot, internal lane l latches `sample_i[l*32 +: 32]` and pulses `take_o[l]` high for exactly one system clock. The source must then present the next word before that lane's next enabled slot.
- R8: Output pin j carries the internal lane whose index equals the 4-bit field `swap_map_i[4*j +: 4]`; 0x76543210 is the identity. A field value of 4 or more drives the pin to 0.
- R9: While `enable_i` is 0 or either `clr_out_i` or `clr_in_i` is 1, every pin is 0 within one system clock and no take strobe pulses. After enabling, output resumes only from the next active frame-sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, sampled on clk_i |
| fsync_i | input | 1 | Frame-sync / word-select level |
| enable_i | input | 1 | Run enable |
| clr_out_i | input | 1 | Holds the output timing side clear |
| clr_in_i | input | 1 | Holds the input word side clear |
| ws_invert_i | input | 1 | Inverts fsync_i before edge sensing |
| slot_bits_m1_i | input | 5 | Bits per slot minus one |
| slot_cnt_m1_i | input | 5 | Slots per frame minus one |
| skew_i | input | 5 | Bit clocks from frame edge to first MSB |
| word_msb_i | input | 5 | Word width minus one |
| lane_mask_i | input | 128 | Per-lane slot enables, 32 bits per lane |
| swap_map_i | input | 32 | Eight 4-bit pin-to-lane fields |
| mute_word_i | input | 32 | Word sent in masked-out slots |
| sample_i | input | 128 | Current upstream word per lane |
| take_o | output | 4 | Per-lane word consumed strobe |
| sdo_o | output | 4 | Serial data pins |

## Verification
The bench builds the block with its defaults: four lanes, 32-bit words, 5-bit frame fields (up to 32 slots) and eight 4-bit swap fields. Because there are more swap fields than lanes, a field value that names no lane can be tried. The 32-slot masks allow sparse patterns over frames of 3, 4 and 5 slots. The wide word lets the bench send words narrower than their slots, which shows the zero padding. The runs cover skews of 0, 1 and 2, both frame-sync polarities, and a disable in the middle of a frame.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

   localparam int unsigned TDM_WORD_MAX = 64;

   // Bit 'pos' counted from the MSB of a (msb+1)-bit word; zero past the word.
   function automatic logic pick_bit(input logic [TDM_WORD_MAX-1:0] word,
                                     input logic [6:0] pos,
                                     input logic [6:0] msb);
      logic [6:0] idx;
      idx = msb - pos;
      if (pos > msb) return 1'b0;
      return word[idx[5:0]];
   endfunction

endpackage

// File: rtl/tdm_edge_detect.sv
module tdm_edge_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic bclk_i,
   input  logic ws_i,
   output logic tick_o,
   output logic frame_edge_o
);

   logic bclk_q;
   logic ws_q;

   assign tick_o       = bclk_q & ~bclk_i;
   assign frame_edge_o = tick_o & ws_i & ~ws_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bclk_q <= 1'b0;
         ws_q   <= 1'b1;
      end else begin
         bclk_q <= bclk_i;
         if (clr_i)       ws_q <= 1'b1;
         else if (tick_o) ws_q <= ws_i;
      end
   end

   AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o); // R2

endmodule

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
   parameter int unsigned CW = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic          tick_i,
   input  logic          frame_edge_i,
   input  logic [CW-1:0] bit_max_i,
   input  logic [CW-1:0] slot_max_i,
   input  logic [CW-1:0] skew_i,
   output logic          emit_o,
   output logic [CW-1:0] pos_o,
   output logic [CW-1:0] slot_o
);

   logic          run_q, pend_q, restart;
   logic [CW-1:0] wait_q, pos_q, slot_q;

   always_comb begin
      if (frame_edge_i) restart = (skew_i == '0);
      else              restart = tick_i && pend_q && (wait_q == '0);
      emit_o = en_i && tick_i && (restart || run_q);
      pos_o  = restart ? '0 : pos_q;
      slot_o = restart ? '0 : slot_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
         wait_q <= '0;
         pos_q  <= '0;
         slot_q <= '0;
      end else if (!en_i) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
         wait_q <= '0;
         pos_q  <= '0;
         slot_q <= '0;
      end else if (tick_i) begin
         if (frame_edge_i) begin
            pend_q <= (skew_i != '0);
            wait_q <= skew_i - 1'b1;
         end else if (pend_q) begin
            if (wait_q == '0) pend_q <= 1'b0;
            else              wait_q <= wait_q - 1'b1;
         end
         if (emit_o) begin
            run_q <= 1'b1;
            if (pos_o >= bit_max_i) begin
               pos_q  <= '0;
               slot_q <= (slot_o >= slot_max_i) ? '0 : slot_o + 1'b1;
            end else begin
               pos_q  <= pos_o + 1'b1;
            end
         end
      end
   end

   AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (emit_o && pos_o >= bit_max_i && slot_o >= slot_max_i)
      |=> (slot_q == '0 && pos_q == '0)); // R3

   AST_FRAME_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && frame_edge_i && skew_i == '0)
      |-> (emit_o && pos_o == '0 && slot_o == '0)); // R4

   AST_SKEW_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && frame_edge_i && skew_i != '0) |=> pend_q); // R4

endmodule

// File: rtl/tdm_lane_shift.sv
module tdm_lane_shift
   import tdm_ser_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned CW    = 5,
   parameter int unsigned NSLOT = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic             emit_i,
   input  logic [CW-1:0]    pos_i,
   input  logic [CW-1:0]    slot_i,
   input  logic [CW-1:0]    word_msb_i,
   input  logic [NSLOT-1:0] mask_i,
   input  logic [DW-1:0]    mute_i,
   input  logic [DW-1:0]    sample_i,
   output logic             take_o,
   output logic             bit_o
);

   logic          start, use_data, nxt_bit;
   logic [DW-1:0] word_q, word_now;

   always_comb begin
      start    = emit_i && (pos_i == '0);
      use_data = mask_i[slot_i];
      word_now = start ? (use_data ? sample_i : mute_i) : word_q;
      nxt_bit  = pick_bit(TDM_WORD_MAX'(word_now), 7'(pos_i), 7'(word_msb_i));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_q <= '0;
         take_o <= 1'b0;
         bit_o  <= 1'b0;
      end else begin
         take_o <= start && use_data && !clr_i;
         if (clr_i)      word_q <= '0;
         else if (start) word_q <= word_now;
         if (!en_i)       bit_o <= 1'b0;
         else if (emit_i) bit_o <= nxt_bit;
      end
   end

   AST_TAKE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |=> !take_o); // R7

   AST_MASKED_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> $past(use_data)); // R6

   AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!bit_o && !take_o)); // R9

endmodule

// File: rtl/tdm_frame_serializer.sv
module tdm_frame_serializer #(
   parameter int unsigned LANES       = 4,
   parameter int unsigned DW          = 32,
   parameter int unsigned CW          = 5,
   parameter int unsigned SWAP_FIELDS = 8,
   parameter int unsigned SWAP_FW     = 4,
   localparam int unsigned NSLOT      = 1 << CW,
   localparam int unsigned SWAP_W     = SWAP_FIELDS * SWAP_FW
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   bclk_i,
   input  logic                   fsync_i,
   input  logic                   enable_i,
   input  logic                   clr_out_i,
   input  logic                   clr_in_i,
   input  logic                   ws_invert_i,
   input  logic [CW-1:0]          slot_bits_m1_i,
   input  logic [CW-1:0]          slot_cnt_m1_i,
   input  logic [CW-1:0]          skew_i,
   input  logic [CW-1:0]          word_msb_i,
   input  logic [LANES*NSLOT-1:0] lane_mask_i,
   input  logic [SWAP_W-1:0]      swap_map_i,
   input  logic [DW-1:0]          mute_word_i,
   input  logic [LANES*DW-1:0]    sample_i,
   output logic [LANES-1:0]       take_o,
   output logic [LANES-1:0]       sdo_o
);

   if (LANES < 1 || LANES > SWAP_FIELDS) begin : g_bad_lanes
      $error("LANES must be between 1 and SWAP_FIELDS");
   end
   if ((1 << SWAP_FW) < LANES) begin : g_bad_swap
      $error("SWAP_FW too narrow to name every lane");
   end
   if (DW < 1 || DW > 64) begin : g_bad_dw
      $error("DW must be between 1 and 64");
   end
   if (CW < 1 || CW > 6) begin : g_bad_cw
      $error("CW must be between 1 and 6");
   end

   logic             en_eff, ws_sense, tick, frame_edge, emit;
   logic [CW-1:0]    pos, slot;
   logic [LANES-1:0] lane_bit;

   assign en_eff   = enable_i & ~clr_out_i & ~clr_in_i;
   assign ws_sense = fsync_i ^ ws_invert_i;

   tdm_edge_detect u_edge (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (clr_out_i),
      .bclk_i       (bclk_i),
      .ws_i         (ws_sense),
      .tick_o       (tick),
      .frame_edge_o (frame_edge)
   );

   tdm_slot_timer #(.CW(CW)) u_timer (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (en_eff),
      .tick_i       (tick),
      .frame_edge_i (frame_edge),
      .bit_max_i    (slot_bits_m1_i),
      .slot_max_i   (slot_cnt_m1_i),
      .skew_i       (skew_i),
      .emit_o       (emit),
      .pos_o        (pos),
      .slot_o       (slot)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      tdm_lane_shift #(.DW(DW), .CW(CW), .NSLOT(NSLOT)) u_lane (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .clr_i      (clr_in_i),
         .en_i       (en_eff),
         .emit_i     (emit),
         .pos_i      (pos),
         .slot_i     (slot),
         .word_msb_i (word_msb_i),
         .mask_i     (lane_mask_i[l*NSLOT +: NSLOT]),
         .mute_i     (mute_word_i),
         .sample_i   (sample_i[l*DW +: DW]),
         .take_o     (take_o[l]),
         .bit_o      (lane_bit[l])
      );
   end

   // Pin routing: each pin selects an internal lane by index; unknown index gives 0.
   always_comb begin
      for (int j = 0; j < LANES; j++) begin
         sdo_o[j] = 1'b0;
         for (int k = 0; k < LANES; k++) begin
            if (swap_map_i[j*SWAP_FW +: SWAP_FW] == SWAP_FW'(k)) sdo_o[j] = lane_bit[k];
         end
      end
   end

   AST_PINS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_eff |=> (sdo_o == '0)); // R9

   AST_NO_TAKE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_eff |=> (take_o == '0)); // R9

endmodule

// File: tb/tdm_frame_serializer_tb.sv
`timescale 1ns/1ps
module tdm_frame_serializer_tb;
   localparam int LANES = 4;
   localparam int DW    = 32;
   localparam int CW    = 5;
   localparam int NSLOT = 32;
   localparam int IDLE  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0, fsync = 1'b0, enable = 1'b0, clr_out = 1'b0, clr_in = 1'b0, ws_inv = 1'b0;
   logic [CW-1:0] c_bm1 = '0, c_sm1 = '0, c_skew = '0, c_msb = '0;
   logic [LANES*NSLOT-1:0] c_mask = '0;
   logic [31:0] c_swap = 32'h76543210;
   logic [DW-1:0] c_mute = '0;
   logic [LANES*DW-1:0] sample;
   logic [LANES-1:0] take, sdo;

   int errors = 0, checks = 0;
   bit done = 1'b0;
   int take_cnt [LANES];
   logic [LANES-1:0] exp_q [$];
   string tag_q [$];

   always #2.5 clk = ~clk;

   tdm_frame_serializer u_dut (
      .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fsync_i(fsync), .enable_i(enable),
      .clr_out_i(clr_out), .clr_in_i(clr_in), .ws_invert_i(ws_inv),
      .slot_bits_m1_i(c_bm1), .slot_cnt_m1_i(c_sm1), .skew_i(c_skew), .word_msb_i(c_msb),
      .lane_mask_i(c_mask), .swap_map_i(c_swap), .mute_word_i(c_mute), .sample_i(sample),
      .take_o(take), .sdo_o(sdo)
   );

   function automatic logic [31:0] pat(input int l, input int n);
      return (32'(n + 1) * 32'h9E3779B9) ^ (32'(l) * 32'h13579BDF) ^ 32'h0F0F3C3C;
   endfunction

   always_comb begin
      for (int l = 0; l < LANES; l++) sample[l*DW +: DW] = pat(l, take_cnt[l]);
   end

   always @(negedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (!rst_n) take_cnt[l] <= 0;
         else if (take[l]) take_cnt[l] <= take_cnt[l] + 1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: one expected pin vector per falling bit clock.
   initial begin
      forever begin
         @(negedge bclk);
         @(negedge clk);
         if (exp_q.size() > 0) begin
            logic [LANES-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(sdo === e, t, 32'(sdo), 32'(e));
         end
      end
   end

   task automatic do_reset();
      rst_n = 1'b0; bclk = 1'b0; enable = 1'b0; clr_out = 1'b0; clr_in = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // Driver + reference model. off: tick from which output is expected off (enable dropped).
   task automatic run_scn(input int nfr, input int off, input bit quiet, input string tag);
      int nb, ns, fr, total, h, r, w, sl, ps, sel;
      int mc [LANES];
      logic [DW-1:0] cw [LANES];
      logic [LANES-1:0] ib, ev;
      bit wsv, on;
      nb = int'(c_bm1) + 1; ns = int'(c_sm1) + 1; fr = nb * ns;
      h = (fr / 2 > 0) ? fr / 2 : 1;
      total = IDLE + nfr * fr + int'(c_skew);
      for (int l = 0; l < LANES; l++) begin mc[l] = 0; cw[l] = '0; end
      for (int i = 0; i < total; i++) begin
         wsv = (i >= IDLE) && (((i - IDLE) % fr) < h);
         on  = !quiet && (off < 0 || i < off);
         r   = i - IDLE - int'(c_skew);
         ib  = '0;
         if (on && r >= 0) begin
            w = r % fr; sl = w / nb; ps = w % nb;
            for (int l = 0; l < LANES; l++) begin
               if (ps == 0) begin
                  if (c_mask[l*NSLOT + sl]) begin cw[l] = pat(l, mc[l]); mc[l]++; end
                  else cw[l] = c_mute;
               end
               ib[l] = (ps <= int'(c_msb)) ? cw[l][int'(c_msb) - ps] : 1'b0;
            end
         end
         for (int j = 0; j < LANES; j++) begin
            sel = int'(c_swap[j*4 +: 4]);
            ev[j] = (sel < LANES) ? ib[sel] : 1'b0;
         end
         exp_q.push_back(ev);
         tag_q.push_back(tag);
         @(negedge clk);
         fsync = wsv ^ ws_inv;
         bclk  = 1'b1;
         if (i == off) enable = 1'b0;
         @(negedge clk);
         @(negedge clk);
         bclk = 1'b0;
         @(negedge clk);
      end
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
      for (int l = 0; l < LANES; l++)
         check(take_cnt[l] == mc[l], "R6 R7 take count", 32'(take_cnt[l]), 32'(mc[l]));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state
      check(sdo === '0, "R1 sdo after reset", 32'(sdo), 32'd0);
      check(take === '0, "R1 take after reset", 32'(take), 32'd0);

      // R2 R3 R4 R7: 4 slots x 8 bits, skew 1, all slots enabled, identity map
      c_bm1 = 5'd7; c_sm1 = 5'd3; c_skew = 5'd1; c_msb = 5'd7; ws_inv = 1'b0;
      c_mask = {LANES{32'hFFFF_FFFF}}; c_swap = 32'h76543210; c_mute = '0;
      enable = 1'b1;
      run_scn(3, -1, 1'b0, "R2 R3 R4 R7 stream");

      // R9: enable with output clear held
      do_reset();
      clr_out = 1'b1; enable = 1'b1;
      run_scn(1, -1, 1'b1, "R9 clr_out quiet");
      // R9: enable with input clear held
      do_reset();
      clr_in = 1'b1; enable = 1'b1;
      run_scn(1, -1, 1'b1, "R9 clr_in quiet");

      // R5 R6 R8 R2: 3 slots x 16 bits, 12-bit words, skew 2, inverted sync, reversed map
      do_reset();
      c_bm1 = 5'd15; c_sm1 = 5'd2; c_skew = 5'd2; c_msb = 5'd11; ws_inv = 1'b1;
      c_mask = {32'h0, 32'h7, 32'h2, 32'h5}; c_swap = 32'h76540123; c_mute = 32'h0000_0A5C;
      enable = 1'b1;
      run_scn(2, -1, 1'b0, "R5 R6 R8 R2 pad");

      // R3 R4 R6 R8: 5 slots x 4 bits, skew 0, one pin mapped to a missing lane
      do_reset();
      c_bm1 = 5'd3; c_sm1 = 5'd4; c_skew = 5'd0; c_msb = 5'd3; ws_inv = 1'b0;
      c_mask = {32'h10, 32'h01, 32'h1F, 32'h1B}; c_swap = 32'h76540291; c_mute = 32'h5;
      enable = 1'b1;
      run_scn(3, -1, 1'b0, "R3 R4 R6 R8 map");

      // R9: enable dropped in mid frame
      do_reset();
      c_bm1 = 5'd7; c_sm1 = 5'd3; c_skew = 5'd1; c_msb = 5'd7;
      c_mask = {LANES{32'hFFFF_FFFF}}; c_swap = 32'h76543210; c_mute = '0;
      enable = 1'b1;
      run_scn(2, IDLE + 32 + 10, 1'b0, "R9 disable");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule